// File: doc/BRIEF.md
# HDLC-Style Frame Receive Controller

This block sits between a byte-level deframer and a shared receive buffer. The deframer hands it single-cycle strobes marking the opening flag, each received byte, and the closing flag. The controller stores every byte in sequence in the receive area of the buffer and runs a CRC-16 over the whole frame, including the two trailing check bytes. Buffer writes go out through a request/acknowledge port.

When a frame is closed properly, the controller writes two status bytes at fixed buffer locations. One is a pass/fail checksum flag. The other is either the payload length or an error code. It then raises a one-cycle interrupt so the host can fetch the frame. Frames that are never closed, and anything received while the bit clock is reported missing, leave the status bytes untouched.

Top module: `hrx_frame_rx`

## Requirements
- R1: Byte number i of a frame (counting from 0) is written to buffer address 0x100+i, in arrival order, for i from 0 to 253 (the last data location is 0x1FD).
- R2: A buffer write holds `buf_req` high with stable `buf_addr` and `buf_wdata` until `buf_ack` is seen. `buf_req` is low in the cycle after the acknowledge. Only one write is outstanding at a time.
- R3: The CRC uses polynomial 0x1021, processes bits MSB first, and starts from a parameter value (default 0x0000). The sender appends the CRC high byte first, and a frame passes when the register is zero after all bytes. A passing frame of N bytes (N from 2 to 254) gets length byte N-2 at 0x1FF and checksum byte 0xFF at 0x1FE.
- R4: A frame of 2 to 254 bytes that fails the CRC gets length byte 0xFE at 0x1FF and checksum byte 0x00 at 0x1FE.
- R5: A frame of more than 254 bytes, or of fewer than 2 bytes, gets length byte 0xFF. Bytes past the 254th are not written. The checksum byte still reports the CRC result.
- R6: For every closed frame exactly two status writes follow the data writes: 0x1FE first, then 0x1FF.
- R7: `rx_irq` is a single-cycle pulse, exactly one per closed frame. It is high in the second cycle after the cycle in which the length-byte write is acknowledged.
- R8: A stop strobe with no open frame causes no buffer write and no interrupt.
- R9: A start strobe during an open frame discards it: the write pointer returns to 0x100 and the CRC restarts.
- R10: While `bclk_ok` is low, start, byte and stop strobes are ignored. A drop of `bclk_ok` during a frame abandons that frame, so its later bytes and stop produce no writes and no interrupt.
- R11: During and right after reset, `buf_req` and `rx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_ok | input | 1 | Bit clock present |
| rx_start | input | 1 | Opening flag strobe |
| rx_stop | input | 1 | Closing flag strobe |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| buf_req | output | 1 | Buffer write request |
| buf_addr | output | 9 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| buf_ack | input | 1 | Buffer write acknowledge |
| rx_irq | output | 1 | Frame-received interrupt pulse |

## Verification
A byte's write request is raised one cycle after its strobe. The status writes start the cycle after the stop strobe, once the port is idle, and the interrupt follows two edges after the length write's acknowledge. The bench drives strobes with a seven-cycle spacing, so every data write finishes before the next byte, even with an acknowledge latency that rotates through 0, 1 and 2 cycles. It records the exact cycle of the length-write acknowledge and of the interrupt and checks their distance. It reads the buffer contents only after a 30-cycle settle window that follows each stop.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_DRAIN,
    ST_WR_LEN,
    ST_FIN
  } rx_state_e;

  // One byte through the CRC register, MSB first, no reflection.
  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] crc_in,
                                                  input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[CRC_W-1] ^ din[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                     c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/hrx_reset_sync.sv
module hrx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/hrx_crc16.sv
module hrx_crc16 import hrx_pkg::*; #(
  parameter logic [CRC_W-1:0] CRC_INIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_INIT;
    else if (en) crc_d = crc16_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/hrx_wr_port.sv
module hrx_wr_port #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_data,
  output logic              busy,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  input  logic              ack
);

  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    data_d = data_q;
    if (req_q) begin
      if (ack) req_d = 1'b0;
    end else if (issue) begin
      req_d  = 1'b1;
      addr_d = issue_addr;
      data_d = issue_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy  = req_q;
  assign req   = req_q;
  assign addr  = addr_q;
  assign wdata = data_q;

endmodule

// File: rtl/hrx_frame_fsm.sv
module hrx_frame_fsm import hrx_pkg::*; #(
  parameter int                ADDR_W       = 9,
  parameter int                BUF_BASE     = 'h100,
  parameter int                BUF_LAST     = 'h1FD,
  parameter int                CSUM_ADDR    = 'h1FE,
  parameter int                LEN_ADDR     = 'h1FF,
  parameter logic [CRC_W-1:0]  CRC_RESIDUE  = 16'h0000,
  parameter logic [BYTE_W-1:0] CODE_CRC_ERR = 8'hFE,
  parameter logic [BYTE_W-1:0] CODE_LEN_ERR = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_ok,
  input  logic              start,
  input  logic              stop,
  input  logic              valid,
  input  logic [BYTE_W-1:0] data,
  input  logic [CRC_W-1:0]  crc,
  input  logic              wr_busy,
  output logic              wr_issue,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              irq
);

  localparam int DEPTH = BUF_LAST - BUF_BASE + 1;
  localparam int CNT_W = $clog2(DEPTH + 2);
  localparam logic [CNT_W-1:0]  DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0]  CRCB_C   = CNT_W'(2);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] CSUM_A   = ADDR_W'(CSUM_ADDR);
  localparam logic [ADDR_W-1:0] LEN_A    = ADDR_W'(LEN_ADDR);
  localparam logic [BYTE_W-1:0] FLAG_OK  = '1;
  localparam logic [BYTE_W-1:0] FLAG_BAD = '0;

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] len_q, len_d;
  logic [BYTE_W-1:0] csum_q, csum_d;
  logic              irq_q, irq_d;
  logic              crc_match;

  assign crc_match = (crc == CRC_RESIDUE);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    csum_d   = csum_q;
    irq_d    = 1'b0;
    wr_issue = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (bclk_ok && start) begin
          crc_clr = 1'b1;
          cnt_d   = '0;
          state_d = ST_RECV;
        end
      end

      ST_RECV: begin
        if (!bclk_ok) begin
          state_d = ST_IDLE;
        end else if (start) begin
          crc_clr = 1'b1;
          cnt_d   = '0;
        end else if (stop) begin
          csum_d = crc_match ? FLAG_OK : FLAG_BAD;
          if (cnt_q > DEPTH_C || cnt_q < CRCB_C) len_d = CODE_LEN_ERR;
          else if (!crc_match)                   len_d = CODE_CRC_ERR;
          else                                   len_d = BYTE_W'(cnt_q - CRCB_C);
          state_d = ST_DRAIN;
        end else if (valid) begin
          crc_en = 1'b1;
          if (cnt_q < DEPTH_C) begin
            wr_issue = 1'b1;
            wr_addr  = BASE_A + ADDR_W'(cnt_q);
            wr_data  = data;
          end
          if (cnt_q <= DEPTH_C) cnt_d = cnt_q + 1'b1;
        end
      end

      ST_DRAIN: begin
        if (!wr_busy) begin
          wr_issue = 1'b1;
          wr_addr  = CSUM_A;
          wr_data  = csum_q;
          state_d  = ST_WR_LEN;
        end
      end

      ST_WR_LEN: begin
        if (!wr_busy) begin
          wr_issue = 1'b1;
          wr_addr  = LEN_A;
          wr_data  = len_q;
          state_d  = ST_FIN;
        end
      end

      ST_FIN: begin
        if (!wr_busy) begin
          irq_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      csum_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      csum_q  <= csum_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/hrx_frame_rx.sv
module hrx_frame_rx import hrx_pkg::*; #(
  parameter int                ADDR_W       = 9,
  parameter int                BUF_BASE     = 'h100,
  parameter int                BUF_LAST     = 'h1FD,
  parameter int                CSUM_ADDR    = 'h1FE,
  parameter int                LEN_ADDR     = 'h1FF,
  parameter logic [15:0]       CRC_INIT     = 16'h0000,
  parameter logic [15:0]       CRC_RESIDUE  = 16'h0000,
  parameter logic [7:0]        CODE_CRC_ERR = 8'hFE,
  parameter logic [7:0]        CODE_LEN_ERR = 8'hFF,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_ok,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              buf_req,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  input  logic              buf_ack,
  output logic              rx_irq
);

  logic              rst_n_i;
  logic              crc_clr, crc_en;
  logic [CRC_W-1:0]  crc_val;
  logic              wr_issue, wr_busy;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  hrx_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  hrx_crc16 #(.CRC_INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (rx_data),
    .crc   (crc_val)
  );

  hrx_frame_fsm #(
    .ADDR_W       (ADDR_W),
    .BUF_BASE     (BUF_BASE),
    .BUF_LAST     (BUF_LAST),
    .CSUM_ADDR    (CSUM_ADDR),
    .LEN_ADDR     (LEN_ADDR),
    .CRC_RESIDUE  (CRC_RESIDUE),
    .CODE_CRC_ERR (CODE_CRC_ERR),
    .CODE_LEN_ERR (CODE_LEN_ERR)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .bclk_ok  (bclk_ok),
    .start    (rx_start),
    .stop     (rx_stop),
    .valid    (rx_valid),
    .data     (rx_data),
    .crc      (crc_val),
    .wr_busy  (wr_busy),
    .wr_issue (wr_issue),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .crc_clr  (crc_clr),
    .crc_en   (crc_en),
    .irq      (rx_irq)
  );

  hrx_wr_port #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .issue      (wr_issue),
    .issue_addr (wr_addr),
    .issue_data (wr_data),
    .busy       (wr_busy),
    .req        (buf_req),
    .addr       (buf_addr),
    .wdata      (buf_wdata),
    .ack        (buf_ack)
  );

endmodule

// File: rtl/hrx_frame_rx_chk.sv
module hrx_frame_rx_chk #(
  parameter int ADDR_W   = 9,
  parameter int BUF_BASE = 'h100,
  parameter int LEN_ADDR = 'h1FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_req,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [7:0]        buf_wdata,
  input logic              buf_ack,
  input logic              rx_irq
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && !buf_ack) |=> (buf_req && $stable(buf_addr) && $stable(buf_wdata))); // R2

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && buf_ack) |=> !buf_req); // R2

  AST_ADDR_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    buf_req |-> (buf_addr >= ADDR_W'(BUF_BASE))); // R1

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R7

  AST_IRQ_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(buf_req && buf_ack && (buf_addr == ADDR_W'(LEN_ADDR)), 2)); // R7

  AST_IRQ_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !buf_req); // R6

endmodule

bind hrx_frame_rx hrx_frame_rx_chk #(
  .ADDR_W   (ADDR_W),
  .BUF_BASE (BUF_BASE),
  .LEN_ADDR (LEN_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_req   (buf_req),
  .buf_addr  (buf_addr),
  .buf_wdata (buf_wdata),
  .buf_ack   (buf_ack),
  .rx_irq    (rx_irq)
);

// File: tb/tb_hrx_frame_rx.sv
`timescale 1ns/1ps
module tb_hrx_frame_rx;

  localparam int BASE = 'h100;
  localparam int CSUM = 'h1FE;
  localparam int LENA = 'h1FF;
  localparam int CAP  = 254;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bclk_ok;
  logic       rx_start, rx_stop, rx_valid;
  logic [7:0] rx_data;
  logic       buf_req;
  logic [8:0] buf_addr;
  logic [7:0] buf_wdata;
  logic       buf_ack;
  logic       rx_irq;

  always #2 clk = ~clk;

  hrx_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_ok(bclk_ok),
    .rx_start(rx_start), .rx_stop(rx_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .buf_req(buf_req), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_ack(buf_ack),
    .rx_irq(rx_irq)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] mem [0:511];
  logic [7:0] fb  [0:299];
  int cyc = 0, wr_cnt = 0, irq_cnt = 0, dly = 0, lat_rot = 1;
  int csum_seq = 0, len_seq = 0, len_done_cyc = 0, irq_cyc = 0;

  // Buffer model: acknowledge latency rotates through 0, 1, 2 extra cycles.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_req && buf_ack && buf_addr == 9'(LENA)) len_done_cyc = cyc;
    if (rx_irq) begin irq_cnt++; irq_cyc = cyc; end
    if (!rst_n) buf_ack <= 1'b0;
    else if (buf_ack) buf_ack <= 1'b0;
    else if (buf_req) begin
      if (dly == 0) begin
        buf_ack <= 1'b1;
        mem[buf_addr] = buf_wdata;
        wr_cnt++;
        if (buf_addr == 9'(CSUM)) csum_seq = wr_cnt;
        if (buf_addr == 9'(LENA)) len_seq  = wr_cnt;
        dly = lat_rot;
        lat_rot = (lat_rot + 1) % 3;
      end else dly--;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fbk = c[15] ^ fb[i][b];
        c = {c[14:0], 1'b0};
        if (fbk) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    rx_start = 1'b1; tick(1); rx_start = 1'b0; tick(2);
  endtask

  task automatic pulse_stop();
    rx_stop = 1'b1; tick(1); rx_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; tick(1); rx_valid = 1'b0; tick(6);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h5A;
  endtask

  // Sends fb[0..t-1] as one closed frame and checks every result.
  task automatic run_raw(input int t, input string tag);
    int irq0, wr0, errs, ok, exp_len, stored;
    clear_mem();
    irq0 = irq_cnt; wr0 = wr_cnt;
    ok = (ref_crc(t) == 16'h0000);
    if (t > CAP || t < 2) exp_len = 'hFF;
    else if (!ok)         exp_len = 'hFE;
    else                  exp_len = t - 2;
    pulse_start();
    for (int i = 0; i < t; i++) send_byte(fb[i]);
    pulse_stop();
    tick(30);
    check({tag, " length byte"}, int'(mem[LENA]), exp_len);
    check({tag, " checksum byte"}, int'(mem[CSUM]), ok ? 'hFF : 'h00);
    stored = (t > CAP) ? CAP : t;
    errs = 0;
    for (int i = 0; i < stored; i++) if (mem[BASE + i] !== fb[i]) errs++;
    check("R1 payload mismatches", errs, 0);
    check((t > CAP) ? "R5 write count" : "R1 write count", wr_cnt - wr0, stored + 2);
    check("R6 status order", len_seq - csum_seq, 1);
    check("R7 irq count", irq_cnt - irq0, 1);
    check("R7 irq delay", irq_cyc - len_done_cyc, 2);
  endtask

  task automatic build(input int n, input bit corrupt);
    logic [15:0] c;
    for (int i = 0; i < n; i++) fb[i] = 8'(i * 37 + n * 11 + 1);
    c = ref_crc(n);
    fb[n]     = c[15:8];
    fb[n + 1] = c[7:0] ^ (corrupt ? 8'h01 : 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int irq0, wr0;
    rst_n = 1'b0; bclk_ok = 1'b1;
    rx_start = 1'b0; rx_stop = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    tick(3);
    check("R11 req in reset", int'(buf_req), 0);
    check("R11 irq in reset", int'(rx_irq), 0);
    rst_n = 1'b1;
    tick(6);
    check("R11 req after reset", int'(buf_req), 0);
    check("R11 irq after reset", int'(rx_irq), 0);

    // R3: good frames, short and near-full payloads
    for (int p = 0; p <= 20; p++) begin build(p, 1'b0); run_raw(p + 2, "R3"); end
    for (int p = 240; p <= 252; p++) begin build(p, 1'b0); run_raw(p + 2, "R3"); end

    // R4: corrupted check bytes
    build(1, 1'b1);   run_raw(3, "R4");
    build(5, 1'b1);   run_raw(7, "R4");
    build(100, 1'b1); run_raw(102, "R4");
    build(252, 1'b1); run_raw(254, "R4");

    // R5: overflow and too-short frames
    build(253, 1'b0); run_raw(255, "R5");
    build(260, 1'b0); run_raw(262, "R5");
    run_raw(0, "R5");
    fb[0] = 8'h3C; run_raw(1, "R5");

    // R8: stop with no open frame
    clear_mem(); irq0 = irq_cnt; wr0 = wr_cnt;
    pulse_stop(); tick(30);
    check("R8 writes on lone stop", wr_cnt - wr0, 0);
    check("R8 irq on lone stop", irq_cnt - irq0, 0);
    check("R8 length byte untouched", int'(mem[LENA]), 'h5A);

    // R9: restart discards partial frame
    clear_mem(); irq0 = irq_cnt; wr0 = wr_cnt;
    pulse_start();
    for (int i = 0; i < 5; i++) send_byte(8'hE0 + 8'(i));
    build(3, 1'b0);
    pulse_start();
    for (int i = 0; i < 5; i++) send_byte(fb[i]);
    pulse_stop(); tick(30);
    check("R9 length after restart", int'(mem[LENA]), 3);
    check("R9 checksum after restart", int'(mem[CSUM]), 'hFF);
    check("R9 first byte rewritten", int'(mem[BASE]), int'(fb[0]));
    check("R9 irq count", irq_cnt - irq0, 1);
    check("R9 write count", wr_cnt - wr0, 12);

    // R10: bit clock absent for a whole frame
    clear_mem(); irq0 = irq_cnt; wr0 = wr_cnt;
    bclk_ok = 1'b0;
    build(4, 1'b0);
    pulse_start();
    for (int i = 0; i < 6; i++) send_byte(fb[i]);
    pulse_stop(); tick(30);
    check("R10 writes without clock", wr_cnt - wr0, 0);
    check("R10 irq without clock", irq_cnt - irq0, 0);
    bclk_ok = 1'b1; tick(2);

    // R10: bit clock lost mid-frame
    clear_mem(); irq0 = irq_cnt; wr0 = wr_cnt;
    pulse_start();
    for (int i = 0; i < 3; i++) send_byte(fb[i]);
    bclk_ok = 1'b0; tick(5); bclk_ok = 1'b1; tick(2);
    for (int i = 3; i < 6; i++) send_byte(fb[i]);
    pulse_stop(); tick(30);
    check("R10 writes before loss only", wr_cnt - wr0, 3);
    check("R10 irq after loss", irq_cnt - irq0, 0);
    check("R10 length byte untouched", int'(mem[LENA]), 'h5A);

    // recovery: a clean frame still works
    build(7, 1'b0); run_raw(9, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule